// File: doc/BRIEF.md
# Keyed flash erase controller

This block is the register front-end of an embedded flash erase engine. Software reaches it through a simple 32-bit register port: one write strobe, a byte offset, write data and combinational read data. A control register stays locked from reset until software writes two fixed key words, in the right order, to the key register. A wrong key or a wrong order freezes the lock until the next reset, and later correct keys then have no effect.

While unlocked, software picks page erase or mass erase in the control register and sets the start bit. The page to erase is taken from the address register, which is captured when the operation starts. The controller raises busy on the next cycle and offers the request on a valid/ready erase port. Once the array accepts it, the controller counts a parameterised duration, which is longer for mass erase than for page erase. Busy and the start bit then fall together and the end-of-operation flag is set.

The erase port follows the usual valid/ready rules. Once `erase_valid` rises, it and the `erase_mass` and `erase_addr` qualifiers hold steady until a cycle in which `erase_ready` is high. That cycle is the transfer, and the duration count begins after it. Holding `erase_ready` low stretches busy by one cycle for each cycle of back-pressure.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the control register (offset 0x10) reads 0x00000080 (lock bit 7 set), status (0x0C) reads 0, address (0x14) reads 0, and `erase_valid` is low.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04), as its next two writes, clears control bit 7 from the cycle after the second write.
- R3: Any other value, or the two keys in the other order, in either key slot freezes the lock: control bit 7 stays 1 until reset, even after correct keys are written later.
- R4: While locked, a control write with bit 7 clear has no effect: control still reads 0x80, and a start request (bit 6) asserts neither busy nor `erase_valid`.
- R5: While unlocked, a control write with bit 7 set relocks the block and clears both erase-select bits, so control reads 0x80; the other bits of that write are ignored.
- R6: A control write (bit 7 clear) with bit 1 (page) set, bit 2 (mass) clear and bit 6 (start) set starts a page erase. Status bit 0 (busy) and control bit 6 read 1 from the next cycle, `erase_valid` rises with `erase_mass` = 0 and `erase_addr` = the address register value. With `erase_ready` high, busy stays 1 for PAGE_CYC+1 cycles.
- R7: The same write with bit 2 set and bit 1 clear starts a mass erase with `erase_mass` = 1, and busy stays 1 for MASS_CYC+1 cycles when `erase_ready` is high.
- R8: Status bit 5 (end of operation) becomes 1 in the cycle busy falls. Writing status with bit 5 set clears it, and writing status with bit 5 clear leaves it set.
- R9: A start with both or neither of bits 1 and 2 set launches nothing: busy and `erase_valid` stay 0.
- R10: While busy, control writes other than the relock are ignored: no new request starts, the erase-select bits keep their values, and the running operation ends on its original schedule.
- R11: While `erase_valid` is high and `erase_ready` low, `erase_valid`, `erase_mass` and `erase_addr` hold. Each cycle of back-pressure adds one cycle of busy, and writes to the address register during an operation do not change `erase_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| erase_valid | output | 1 | Erase request offered to the array |
| erase_ready | input | 1 | Array accepts the request |
| erase_mass | output | 1 | 1 for mass erase, 0 for page erase |
| erase_addr | output | DATA_W | Page address for the request |

## Verification
The assertions take for granted that the array side obeys valid/ready: `erase_ready` may be held low for any number of cycles but is never needed for progress outside a pending request. They also assume that register writes are single-cycle strobes with stable offset and data. The stimulus drives all register accesses as one-cycle writes at the falling edge. It keeps `erase_ready` high except in one directed back-pressure window, and so stays inside those assumptions. Lock-sequence cases are walked from a table of key pairs, each after a fresh reset, so that a frozen lock never carries into the next case.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam int OFS_KEY  = 4;
  localparam int OFS_STAT = 12;
  localparam int OFS_CTRL = 16;
  localparam int OFS_ADDR = 20;

  localparam int CB_PAGE = 1;
  localparam int CB_MASS = 2;
  localparam int CB_GO   = 6;
  localparam int CB_LOCK = 7;
  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 5;

  typedef enum logic [1:0] {KG_WAIT_A, KG_WAIT_B, KG_OPEN, KG_FROZEN} kg_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_RUN} sq_state_e;
endpackage

// File: rtl/fec_keyguard.sv
module fec_keyguard
  import fec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  input  logic              relock,
  output logic              locked
);
  kg_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KG_WAIT_A: if (key_wr) st_d = (key_val == DATA_W'(KEY_FIRST))  ? KG_WAIT_B : KG_FROZEN;
      KG_WAIT_B: if (key_wr) st_d = (key_val == DATA_W'(KEY_SECOND)) ? KG_OPEN   : KG_FROZEN;
      KG_OPEN:   if (relock) st_d = KG_WAIT_A;
      KG_FROZEN: st_d = KG_FROZEN;
      default:   st_d = KG_FROZEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KG_WAIT_A;
    else        st_q <= st_d;
  end

  assign locked = (st_q != KG_OPEN);
endmodule

// File: rtl/fec_sequencer.sv
module fec_sequencer
  import fec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PAGE_CYC = 16,
  parameter int MASS_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_mass,
  input  logic [DATA_W-1:0] launch_addr,
  input  logic              erase_ready,
  output logic              busy,
  output logic              finish,
  output logic              erase_valid,
  output logic              erase_mass,
  output logic [DATA_W-1:0] erase_addr
);
  localparam int MAX_CYC = (MASS_CYC > PAGE_CYC) ? MASS_CYC : PAGE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  sq_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mass_q;
  logic [DATA_W-1:0] addr_q;

  assign finish = (st_q == SQ_RUN) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      mass_q <= 1'b0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (launch) begin
          st_q   <= SQ_REQ;
          mass_q <= launch_mass;
          addr_q <= launch_addr;
        end
        SQ_REQ: if (erase_ready) begin
          st_q  <= SQ_RUN;
          cnt_q <= mass_q ? CNT_W'(MASS_CYC - 1) : CNT_W'(PAGE_CYC - 1);
        end
        SQ_RUN: begin
          if (cnt_q == '0) st_q <= SQ_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != SQ_IDLE);
  assign erase_valid = (st_q == SQ_REQ);
  assign erase_mass  = mass_q;
  assign erase_addr  = addr_q;
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int PAGE_CYC = 16,
  parameter int MASS_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              erase_valid,
  input  logic              erase_ready,
  output logic              erase_mass,
  output logic [DATA_W-1:0] erase_addr
);
  logic hit_key, hit_stat, hit_ctrl, hit_addr;
  assign hit_key  = (reg_addr == ADDR_W'(OFS_KEY));
  assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
  assign hit_addr = (reg_addr == ADDR_W'(OFS_ADDR));

  logic locked, busy, finish;
  logic sel_page_q, sel_mass_q, eop_q;
  logic [DATA_W-1:0] page_addr_q;

  logic ctl_wr, relock, field_wr, one_sel, launch;
  assign ctl_wr   = reg_wr && hit_ctrl;
  assign relock   = ctl_wr && !locked && reg_wdata[CB_LOCK];
  assign field_wr = ctl_wr && !locked && !busy && !reg_wdata[CB_LOCK];
  assign one_sel  = reg_wdata[CB_PAGE] ^ reg_wdata[CB_MASS];
  assign launch   = field_wr && reg_wdata[CB_GO] && one_sel;

  fec_keyguard #(.DATA_W(DATA_W)) u_keyguard (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (reg_wr && hit_key),
    .key_val (reg_wdata),
    .relock  (relock),
    .locked  (locked)
  );

  fec_sequencer #(.DATA_W(DATA_W), .PAGE_CYC(PAGE_CYC), .MASS_CYC(MASS_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_mass (reg_wdata[CB_MASS]),
    .launch_addr (page_addr_q),
    .erase_ready (erase_ready),
    .busy        (busy),
    .finish      (finish),
    .erase_valid (erase_valid),
    .erase_mass  (erase_mass),
    .erase_addr  (erase_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_page_q  <= 1'b0;
      sel_mass_q  <= 1'b0;
      eop_q       <= 1'b0;
      page_addr_q <= '0;
    end else begin
      if (relock) begin
        sel_page_q <= 1'b0;
        sel_mass_q <= 1'b0;
      end else if (field_wr) begin
        sel_page_q <= reg_wdata[CB_PAGE];
        sel_mass_q <= reg_wdata[CB_MASS];
      end
      if (finish)
        eop_q <= 1'b1;
      else if (reg_wr && hit_stat && reg_wdata[SB_DONE])
        eop_q <= 1'b0;
      if (reg_wr && hit_addr)
        page_addr_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      reg_rdata[CB_LOCK] = locked;
      reg_rdata[CB_GO]   = busy;
      reg_rdata[CB_MASS] = sel_mass_q;
      reg_rdata[CB_PAGE] = sel_page_q;
    end else if (hit_stat) begin
      reg_rdata[SB_BUSY] = busy;
      reg_rdata[SB_DONE] = eop_q;
    end else if (hit_addr) begin
      reg_rdata = page_addr_q;
    end
  end
endmodule

// File: rtl/fec_checker.sv
module fec_checker
  import fec_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              locked,
  input logic              busy,
  input logic              eop,
  input logic              erase_valid,
  input logic              erase_ready,
  input logic              erase_mass,
  input logic [DATA_W-1:0] erase_addr
);
  logic ctl_w, key_w;
  assign ctl_w = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign key_w = reg_wr && (reg_addr == ADDR_W'(OFS_KEY));

  p_bad_key_keeps_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked && key_w && reg_wdata != DATA_W'(KEY_FIRST) && reg_wdata != DATA_W'(KEY_SECOND) |=> locked);

  p_locked_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !busy && ctl_w |=> !busy);

  p_busy_offers_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> erase_valid);

  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eop);

  p_bad_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && !busy && reg_wdata[CB_GO] && (reg_wdata[CB_PAGE] == reg_wdata[CB_MASS]) |=> !busy);

  p_one_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_valid) |-> $rose(busy));

  p_hold_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid && !erase_ready |=> erase_valid && $stable(erase_addr) && $stable(erase_mass));
endmodule

bind flash_erase_ctrl fec_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fec_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .locked      (locked),
  .busy        (busy),
  .eop         (eop_q),
  .erase_valid (erase_valid),
  .erase_ready (erase_ready),
  .erase_mass  (erase_mass),
  .erase_addr  (erase_addr)
);

// File: tb/tb_flash_erase_ctrl.sv
module tb_flash_erase_ctrl;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int PG = 8;
  localparam int MS = 20;
  localparam logic [AW-1:0] A_KEY = 5'h04, A_ST = 5'h0C, A_CR = 5'h10, A_AR = 5'h14;
  localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;

  // {first key, second key, unlock expected}
  localparam int NV = 6;
  localparam logic [64:0] VEC [NV] = '{
    {K1, K2, 1'b1},
    {K2, K1, 1'b0},
    {K1, K1, 1'b0},
    {32'h0, K2, 1'b0},
    {K1, 32'h0, 1'b0},
    {K1, K2 ^ 32'h1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic erase_valid, erase_mass;
  logic erase_ready = 1'b1;
  logic [DW-1:0] erase_addr;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_erase_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_CYC(PG), .MASS_CYC(MS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .erase_valid(erase_valid),
    .erase_ready(erase_ready), .erase_mass(erase_mass), .erase_addr(erase_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] s;
    n = 0;
    rd(A_ST, s);
    while (s[0] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(A_ST, s);
    end
  endtask

  task automatic unlock();
    wr(A_KEY, K1);
    wr(A_KEY, K2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;

    // Key sequence table (R2, R3)
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(A_KEY, VEC[i][64:33]);
      wr(A_KEY, VEC[i][32:1]);
      rd(A_CR, v);
      chk(VEC[i][0] ? "R2 unlock" : "R3 bad sequence locks", {31'b0, v[7]}, {31'b0, ~VEC[i][0]});
      if (!VEC[i][0]) begin
        unlock();
        rd(A_CR, v);
        chk("R3 frozen after good keys", {31'b0, v[7]}, 32'h1);
      end
    end

    // R1 reset state
    do_reset();
    rd(A_CR, v); chk("R1 ctrl reset", v, 32'h80);
    rd(A_ST, v); chk("R1 status reset", v, 32'h0);
    rd(A_AR, v); chk("R1 addr reset", v, 32'h0);
    chk("R1 valid reset", {31'b0, erase_valid}, 32'h0);

    // R4 locked writes ignored
    wr(A_CR, 32'h46);
    rd(A_ST, v); chk("R4 no busy when locked", v, 32'h0);
    chk("R4 no request when locked", {31'b0, erase_valid}, 32'h0);
    rd(A_CR, v); chk("R4 ctrl unchanged", v, 32'h80);

    // R6 page erase
    unlock();
    wr(A_AR, 32'h0000_0123);
    wr(A_CR, 32'h42);
    chk("R6 valid", {31'b0, erase_valid}, 32'h1);
    chk("R6 page kind", {31'b0, erase_mass}, 32'h0);
    chk("R6 page addr", erase_addr, 32'h123);
    rd(A_CR, v); chk("R6 start bit reads busy", v, 32'h42);
    busy_len(n);
    chk("R6 page duration", n, PG + 1);

    // R8 end of operation
    rd(A_ST, v); chk("R8 eop set", v, 32'h20);
    rd(A_CR, v); chk("R6 start bit self clears", v, 32'h02);
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk("R8 write 0 keeps eop", v, 32'h20);
    wr(A_ST, 32'h20);
    rd(A_ST, v); chk("R8 write 1 clears eop", v, 32'h0);

    // R7 mass erase
    wr(A_CR, 32'h44);
    chk("R7 mass kind", {31'b0, erase_mass}, 32'h1);
    busy_len(n);
    chk("R7 mass duration", n, MS + 1);

    // R9 bad selects
    wr(A_CR, 32'h46);
    rd(A_ST, v); chk("R9 both selects no busy", {31'b0, v[0]}, 32'h0);
    chk("R9 both selects no request", {31'b0, erase_valid}, 32'h0);
    wr(A_CR, 32'h40);
    rd(A_ST, v); chk("R9 no select no busy", {31'b0, v[0]}, 32'h0);

    // R10 start while busy ignored
    wr(A_CR, 32'h42);
    wr(A_CR, 32'h44);
    chk("R10 kind unchanged", {31'b0, erase_mass}, 32'h0);
    busy_len(n);
    chk("R10 original schedule", n + 2, PG + 1);
    rd(A_CR, v); chk("R10 selects unchanged", v, 32'h02);
    @(negedge clk);
    chk("R10 no second request", {31'b0, erase_valid}, 32'h0);

    // R11 back-pressure and address capture
    wr(A_AR, 32'h55);
    erase_ready = 1'b0;
    wr(A_CR, 32'h42);
    wr(A_AR, 32'h777);
    chk("R11 valid held", {31'b0, erase_valid}, 32'h1);
    chk("R11 addr held", erase_addr, 32'h55);
    erase_ready = 1'b1;
    busy_len(n);
    chk("R11 stretched duration", n + 2, PG + 3);
    chk("R11 addr after transfer", erase_addr, 32'h55);

    // R5 relock
    wr(A_CR, 32'hC2);
    rd(A_CR, v); chk("R5 relock", v, 32'h80);
    wr(A_CR, 32'h42);
    rd(A_ST, v); chk("R5 locked again no busy", {31'b0, v[0]}, 32'h0);
    unlock();
    rd(A_CR, v); chk("R2 unlock after relock", v, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule